// File: doc/BRIEF.md
# Interpolating Bit-Depth Reduction Table

This block converts a stream of pixel samples of 8 to 12 significant bits into 8-bit samples. In table mode the sample is split into a segment index and a 3-bit fraction. The block fetches the two table entries at either end of that segment and blends them with rounding. The table has 513 eight-bit entries, so the topmost segment also has an upper endpoint. In shift mode the table is skipped and the sample is truncated to its 8 most significant significant bits. A width select tells the block how many low bits of the input sample carry data. Any bits above that width are ignored.

Software loads the table through a simple write port. A write is honoured only in a cycle with no valid input sample, because samples have priority. A small arbiter state machine tracks what the first pipeline stage holds in each cycle:
- `ARB_IDLE`: nothing is held.
- `ARB_PIXEL`: a sample is waiting for the blend.
- `ARB_WRITE`: a latched table write is committing.

Each cycle the arbiter moves to `ARB_PIXEL` when a sample is valid. Otherwise it moves to `ARB_WRITE` when a write is requested. Otherwise it moves to `ARB_IDLE`. These transitions are the same from every state. Results appear two clock cycles after the sample is accepted.

Top module: `pix_depth_lut`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: Every sample presented with `in_valid`=1 yields exactly one result, with `out_valid`=1 two clock edges later. Back-to-back samples yield back-to-back results in the same order.
- R3: With width 12, the segment index is `in_sample[11:3]` and the fraction f is `in_sample[2:0]`. The output is `(T[idx]*(8-f) + T[idx+1]*f + 4) >> 3`, clamped to 255. An input of 4095 blends entries 511 and 512.
- R4: With width 11, the index is `in_sample[10:2]` and f is `{in_sample[1:0],0}`, blended as in R3.
- R5: With width 10, the index is `in_sample[9:1]` and f is `{in_sample[0],00}`, blended as in R3.
- R6: With width 9 the index is `in_sample[8:0]`; with width 8 it is `in_sample[7:0]`. In both cases f is 0, so the output equals that entry.
- R7: `width_sel` is the width as a binary number. Values outside 8..12 act as 12. Input bits at or above the selected width have no effect.
- R8: With `shift_mode`=1 the output is `in_sample[w-1:w-8]` for the effective width w, truncated and not rounded. With `shift_mode`=0 the table path of R3..R6 is used.
- R9: `wr_en`=1 with `in_valid`=0 stores `wr_data` into entry `wr_addr` (0..512). The new value is visible to samples accepted from the following cycle on. `wr_en`=1 in a cycle with `in_valid`=1 is discarded.
- R10: `out_data` keeps its last value while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 12 | Input sample, right-aligned |
| width_sel | input | 4 | Effective input width, 8..12 |
| shift_mode | input | 1 | 1 = truncating shift, 0 = interpolated table |
| wr_en | input | 1 | Table write request |
| wr_addr | input | 10 | Table entry index |
| wr_data | input | 8 | Table entry value |
| out_valid | output | 1 | Result valid |
| out_data | output | 8 | 8-bit result |

## Verification
A wrong index or fraction in the first stage shows up as a wrong `out_data` value two edges after the sample. The table contents used by the bench are non-monotonic, so a swapped endpoint or a mis-selected bit cannot produce the correct value by coincidence. A corrupted arbiter state shows up within the same two edges, either as a missing or extra `out_valid`, or as a table entry that changed when it should not have. The bench exposes that entry by reading it back through a sample with zero fraction.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
    localparam int unsigned SAMPLE_W = 12;
    localparam int unsigned OUT_W    = 8;
    localparam int unsigned ENTRY_W  = 8;
    localparam int unsigned WT_W     = 3;
    localparam int unsigned SEG_AW   = 9;
    localparam int unsigned ENTRIES  = (1 << SEG_AW) + 1;
    localparam int unsigned TBL_AW   = $clog2(ENTRIES);
    localparam int unsigned SEL_W    = 4;
    localparam int unsigned MIN_W    = 8;
    localparam int unsigned ACC_W    = ENTRY_W + WT_W + 1;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_PIXEL = 2'd1,
        ARB_WRITE = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic [SEG_AW-1:0] seg;
        logic [WT_W-1:0]   wt;
        logic [OUT_W-1:0]  shifted;
        logic              use_shift;
    } stage1_t;
endpackage

// File: rtl/pdl_split.sv
module pdl_split
    import pdl_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SEL_W-1:0]    width_sel,
    output logic [SEG_AW-1:0]   seg,
    output logic [WT_W-1:0]     wt,
    output logic [OUT_W-1:0]    shifted
);
    logic [SEL_W-1:0] eff_w;

    always_comb begin
        if (width_sel >= SEL_W'(MIN_W) && width_sel <= SEL_W'(SAMPLE_W))
            eff_w = width_sel;
        else
            eff_w = SEL_W'(SAMPLE_W);
    end

    always_comb begin
        unique case (eff_w)
            4'd12: begin
                seg     = sample[11:3];
                wt      = sample[2:0];
                shifted = sample[11:4];
            end
            4'd11: begin
                seg     = sample[10:2];
                wt      = {sample[1:0], 1'b0};
                shifted = sample[10:3];
            end
            4'd10: begin
                seg     = sample[9:1];
                wt      = {sample[0], 2'b00};
                shifted = sample[9:2];
            end
            4'd9: begin
                seg     = sample[8:0];
                wt      = '0;
                shifted = sample[8:1];
            end
            default: begin
                seg     = {1'b0, sample[7:0]};
                wt      = '0;
                shifted = sample[7:0];
            end
        endcase
    end
endmodule

// File: rtl/pdl_table.sv
module pdl_table
    import pdl_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [TBL_AW-1:0]  waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [SEG_AW-1:0]  seg,
    output logic [ENTRY_W-1:0] lo_q,
    output logic [ENTRY_W-1:0] hi_q
);
    logic [ENTRY_W-1:0] mem [ENTRIES];
    logic [TBL_AW-1:0]  lo_idx;
    logic [TBL_AW-1:0]  hi_idx;

    always_ff @(posedge clk) begin
        if (we && (waddr < TBL_AW'(ENTRIES)))
            mem[waddr] <= wdata;
    end

    always_comb begin
        lo_idx = {1'b0, seg};
        hi_idx = lo_idx + TBL_AW'(1);
        lo_q   = mem[lo_idx];
        hi_q   = mem[hi_idx];
    end
endmodule

// File: rtl/pdl_blend.sv
module pdl_blend
    import pdl_pkg::*;
(
    input  logic [ENTRY_W-1:0] lo,
    input  logic [ENTRY_W-1:0] hi,
    input  logic [WT_W-1:0]    wt,
    output logic [OUT_W-1:0]   res
);
    localparam logic [ACC_W-1:0] FULL  = ACC_W'(1 << WT_W);
    localparam logic [ACC_W-1:0] HALF  = ACC_W'(1 << (WT_W - 1));
    localparam logic [ACC_W-1:0] OUTMX = ACC_W'((1 << OUT_W) - 1);

    logic [ACC_W-1:0] w_hi;
    logic [ACC_W-1:0] w_lo;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] quo;

    always_comb begin
        w_hi = ACC_W'(wt);
        w_lo = FULL - w_hi;
        acc  = ACC_W'(ACC_W'(lo) * w_lo) + ACC_W'(ACC_W'(hi) * w_hi) + HALF;
        quo  = acc >> WT_W;
        if (quo > OUTMX)
            res = OUT_W'(OUTMX);
        else
            res = OUT_W'(quo);
    end
endmodule

// File: rtl/pdl_arb.sv
module pdl_arb
    import pdl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       wr_en,
    output arb_state_t state_q,
    output logic       blend_en,
    output logic       tbl_we
);
    arb_state_t state_d;

    always_comb begin
        if (in_valid)
            state_d = ARB_PIXEL;
        else if (wr_en)
            state_d = ARB_WRITE;
        else
            state_d = ARB_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ARB_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        blend_en = 1'b0;
        tbl_we   = 1'b0;
        unique case (state_q)
            ARB_PIXEL: blend_en = 1'b1;
            ARB_WRITE: tbl_we   = 1'b1;
            default: begin
                blend_en = 1'b0;
                tbl_we   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pix_depth_lut.sv
module pix_depth_lut
    import pdl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SEL_W-1:0]    width_sel,
    input  logic                shift_mode,
    input  logic                wr_en,
    input  logic [TBL_AW-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data
);
    arb_state_t         arb_q;
    logic               blend_en;
    logic               tbl_we;
    stage1_t            s1_q;
    stage1_t            s1_d;
    logic [TBL_AW-1:0]  wa_q;
    logic [ENTRY_W-1:0] wd_q;
    logic [ENTRY_W-1:0] ent_lo;
    logic [ENTRY_W-1:0] ent_hi;
    logic [OUT_W-1:0]   mixed;

    pdl_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wr_en    (wr_en),
        .state_q  (arb_q),
        .blend_en (blend_en),
        .tbl_we   (tbl_we)
    );

    pdl_split u_split (
        .sample    (in_sample),
        .width_sel (width_sel),
        .seg       (s1_d.seg),
        .wt        (s1_d.wt),
        .shifted   (s1_d.shifted)
    );
    assign s1_d.use_shift = shift_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            wa_q <= '0;
            wd_q <= '0;
        end else if (in_valid) begin
            s1_q <= s1_d;
        end else if (wr_en) begin
            wa_q <= wr_addr;
            wd_q <= wr_data;
        end
    end

    pdl_table u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (wa_q),
        .wdata (wd_q),
        .seg   (s1_q.seg),
        .lo_q  (ent_lo),
        .hi_q  (ent_hi)
    );

    pdl_blend u_blend (
        .lo  (ent_lo),
        .hi  (ent_hi),
        .wt  (s1_q.wt),
        .res (mixed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= blend_en;
            if (blend_en)
                out_data <= s1_q.use_shift ? s1_q.shifted : mixed;
        end
    end
endmodule

// File: rtl/pdl_chk.sv
module pdl_chk
    import pdl_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [SEL_W-1:0]    width_sel,
    input logic                shift_mode,
    input logic                wr_en,
    input logic                out_valid,
    input logic [OUT_W-1:0]    out_data,
    input logic                tbl_we
);
    logic                v1, v2;
    logic                sh1, sh2;
    logic                w12_1, w12_2;
    logic [SAMPLE_W-1:0] x1, x2;
    logic                wide;

    assign wide = (width_sel == 4'd12) || (width_sel < 4'd8) || (width_sel > 4'd12);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            sh1 <= 1'b0; sh2 <= 1'b0;
            w12_1 <= 1'b0; w12_2 <= 1'b0;
            x1 <= '0; x2 <= '0;
        end else begin
            v1 <= in_valid;   v2 <= v1;
            sh1 <= shift_mode; sh2 <= sh1;
            w12_1 <= wide;    w12_2 <= w12_1;
            x1 <= in_sample;  x2 <= x1;
        end
    end

    // R2: result valid exactly two edges after an accepted sample
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    // R10: output held between results
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R9: a table commit never follows a cycle with a valid sample
    a_r9_no_write_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> $past(!in_valid));

    // R9: a table commit only follows a write request
    a_r9_write_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> $past(wr_en));

    // R8: shift result for the full-width case
    a_r8_shift_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && v2 && sh2 && w12_2) |-> (out_data == x2[11:4]));
endmodule

bind pix_depth_lut pdl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .width_sel  (width_sel),
    .shift_mode (shift_mode),
    .wr_en      (wr_en),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .tbl_we     (tbl_we)
);

// File: tb/tb_pix_depth_lut.sv
`timescale 1ns/1ps
module tb_pix_depth_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [3:0]  width_sel = 4'd12;
    logic        shift_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        out_valid;
    logic [7:0]  out_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int tbl [513];

    always #4 clk = ~clk;

    pix_depth_lut dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .width_sel(width_sel), .shift_mode(shift_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_width(input int sel);
        if (sel < 8 || sel > 12) return 12;
        return sel;
    endfunction

    function automatic int exp_lut(input int x, input int sel);
        int w, m, a, f;
        w = eff_width(sel);
        m = x % (1 << w);
        if (w == 8) begin
            a = m; f = 0;
        end else begin
            a = m / (1 << (w - 9));
            f = (m * (1 << (12 - w))) % 8;
        end
        exp_lut = (tbl[a] * (8 - f) + tbl[a + 1] * f + 4) / 8;
        if (exp_lut > 255) exp_lut = 255;
    endfunction

    function automatic int exp_shift(input int x, input int sel);
        int w;
        w = eff_width(sel);
        return (x % (1 << w)) / (1 << (w - 8));
    endfunction

    task automatic put_entry(input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'(idx); wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
        tbl[idx] = val;
    endtask

    task automatic run_px(input int x, input int sel, input bit sh, input int exp, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 12'(x); width_sel = 4'(sel); shift_mode = sh;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " no early valid"}, int'(out_valid), 0);
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " data"}, int'(out_data), exp);
    endtask

    task automatic t_reset;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset data", int'(out_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", int'(out_valid), 0);
        check("R1 after reset data", int'(out_data), 0);
    endtask

    task automatic t_load;
        for (int i = 0; i < 513; i++) put_entry(i, (i * 37 + 11) % 256);
    endtask

    task automatic t_w12;
        int xs [5] = '{0, 4095, 1234, 7, 2051};
        foreach (xs[i]) run_px(xs[i], 12, 0, exp_lut(xs[i], 12), "R3");
        check("R3 endpoint 4095", exp_lut(4095, 12), (tbl[511] + tbl[512] * 7 + 4) / 8);
    endtask

    task automatic t_w11;
        run_px(2047, 11, 0, exp_lut(2047, 11), "R4");
        run_px(1029, 11, 0, exp_lut(1029, 11), "R4");
    endtask

    task automatic t_w10;
        run_px(1023, 10, 0, exp_lut(1023, 10), "R5");
        run_px(513, 10, 0, exp_lut(513, 10), "R5");
    endtask

    task automatic t_w98;
        run_px(511, 9, 0, tbl[511], "R6 9b");
        run_px(300, 9, 0, tbl[300], "R6 9b");
        run_px(255, 8, 0, tbl[255], "R6 8b");
        run_px(128, 8, 0, tbl[128], "R6 8b");
    endtask

    task automatic t_sel;
        run_px(1234, 3, 0, exp_lut(1234, 12), "R7 sel3");
        run_px(1234, 15, 0, exp_lut(1234, 12), "R7 sel15");
        run_px(12'hC00 | 12'h123, 10, 0, exp_lut(12'h123, 10), "R7 upper bits");
        run_px(12'hF00 | 12'h0A5, 8, 0, tbl[8'hA5], "R7 upper bits 8b");
    endtask

    task automatic t_shift;
        run_px(4095, 12, 1, 255, "R8 w12");
        run_px(12'h9AF, 12, 1, 8'h9A, "R8 w12");
        run_px(1029, 11, 1, exp_shift(1029, 11), "R8 w11");
        run_px(12'hC00 | 12'h2FF, 10, 1, exp_shift(12'h2FF, 10), "R8 w10");
        run_px(301, 9, 1, 150, "R8 w9");
        run_px(200, 8, 1, 200, "R8 w8");
        run_px(1234, 0, 1, exp_shift(1234, 12), "R8 sel fallback");
    endtask

    task automatic t_stream;
        int xs [4] = '{100, 3000, 17, 4090};
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R2 stream valid", int'(out_valid), 1);
                check("R2 stream data", int'(out_data), exp_lut(xs[c - 2], 12));
            end
            if (c < 4) begin
                in_valid = 1'b1; in_sample = 12'(xs[c]); width_sel = 4'd12; shift_mode = 1'b0;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R2 stream end", int'(out_valid), 0);
    endtask

    task automatic t_write;
        int old5;
        old5 = tbl[5];
        @(negedge clk);
        in_valid = 1'b1; in_sample = 12'd40; width_sel = 4'd12; shift_mode = 1'b0;
        wr_en = 1'b1; wr_addr = 10'd5; wr_data = 8'(old5 ^ 8'hFF);
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check("R9 blocked write sample", int'(out_data), old5);
        run_px(40, 12, 0, old5, "R9 blocked write kept");
        put_entry(6, 8'hC3);
        run_px(48, 12, 0, 8'hC3, "R9 write visible");
        run_px(44, 12, 0, (old5 * 4 + 8'hC3 * 4 + 4) / 8, "R9 blend new entry");
    endtask

    task automatic t_hold;
        int keep;
        run_px(777, 12, 0, exp_lut(777, 12), "R10 setup");
        keep = exp_lut(777, 12);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 valid low", int'(out_valid), 0);
            check("R10 data held", int'(out_data), keep);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_w12();
        t_w11();
        t_w10();
        t_w98();
        t_sel();
        t_shift();
        t_stream();
        t_write();
        t_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule